// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

In a core that interleaves several hardware threads, this block decides each cycle which thread may use the instruction fetch port. Each thread reports its fetch state, whether it is active, and how full its slice of the instruction queue and the load/store queue is. A policy input chooses the arbitration rule. The result is a valid flag and a thread index, both combinational from the current inputs and from the stored rotation order.

Four rules are available. Single-thread mode serves only the lowest-numbered active thread. Rotation keeps an ordered list of thread numbers and grants the first fetch-ready thread nearest the head. That thread then moves to the tail. The two occupancy rules favour the ready thread with the emptiest queue. One code is held back for a branch-count rule, which is not built. Selecting that code, or any undefined code, raises an error flag. While a drain is requested, no thread is granted.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is fetch-ready only when its active bit is 1 and its 3-bit state is 0 (running), 1 (idle) or 4 (fill done); states 2, 3, 5, 6 and 7 never receive a grant.
- R2: With policy code 0 (single thread), the lowest-numbered active thread is granted if it is fetch-ready; otherwise there is no grant, even if a higher thread is ready.
- R3: With policy code 1 (rotation), the grant goes to the first fetch-ready thread found when walking the rotation order from its head.
- R4: On a clock edge where rotation grants a thread, that thread moves to the tail and the others keep their relative order. At any other edge the order is unchanged.
- R5: After reset the rotation order is ascending thread number, so thread 0 is at the head.
- R6: With policy code 3, the grant goes to the fetch-ready thread with the smallest instruction-queue count, and the lower thread number wins a tie.
- R7: With policy code 4, the grant goes to the fetch-ready thread with the smallest load/store-queue count, and the lower thread number wins a tie.
- R8: While drain_req is 1, sel_valid is 0 under every policy, and the rotation order does not change.
- R9: Policy code 2 (reserved branch-count rule) and codes 5 to 7 set policy_err to 1 and give no grant; codes 0, 1, 3 and 4 keep policy_err at 0.
- R10: Whenever sel_valid is 0, sel_tid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NTHR | Per-thread active mask |
| thr_state | input | 3*NTHR | Per-thread fetch state, thread i in bits [3i+2:3i] |
| iq_occ | input | CNT_W*NTHR | Per-thread instruction-queue count, thread i in slice i |
| lsq_occ | input | CNT_W*NTHR | Per-thread load/store-queue count, thread i in slice i |
| policy | input | 3 | Arbitration rule code |
| drain_req | input | 1 | Suppresses all grants |
| sel_valid | output | 1 | A thread is granted this cycle |
| sel_tid | output | TID_W | Granted thread number |
| policy_err | output | 1 | Reserved or undefined policy code selected |

## Verification
Some properties are checked by assertions on every cycle. A grant always names a fetch-ready thread. Drain and reserved codes block all grants. An invalid output carries thread 0. The rotation order is always a permutation of the thread numbers. After a rotation grant the granted thread sits at the tail, and otherwise the order holds still. Other behaviour can only be shown by the bench's reference model over chosen scenarios. This covers which thread a policy should have chosen: minimum-count picks with ties, the single-thread rule's refusal to skip past a stalled lowest thread, and rotation fairness over long runs with mixed readiness.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;

    localparam logic [2:0] ST_RUN       = 3'd0;
    localparam logic [2:0] ST_IDLE      = 3'd1;
    localparam logic [2:0] ST_FILL_DONE = 3'd4;

    localparam logic [2:0] POL_SINGLE = 3'd0;
    localparam logic [2:0] POL_ROTATE = 3'd1;
    localparam logic [2:0] POL_BRANCH = 3'd2;
    localparam logic [2:0] POL_IQ     = 3'd3;
    localparam logic [2:0] POL_LSQ    = 3'd4;

    function automatic logic state_ready(input logic [2:0] st);
        return (st == ST_RUN) || (st == ST_IDLE) || (st == ST_FILL_DONE);
    endfunction

    function automatic logic policy_known(input logic [2:0] p);
        return (p == POL_SINGLE) || (p == POL_ROTATE) || (p == POL_IQ) || (p == POL_LSQ);
    endfunction

endpackage

// File: rtl/fsel_min_pick.sv
`timescale 1ns/1ps
module fsel_min_pick #(
    parameter int NTHR  = 4,
    parameter int CNT_W = 6,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic [NTHR-1:0]       cand,
    input  logic [NTHR*CNT_W-1:0] counts,
    output logic                  found,
    output logic [TID_W-1:0]      tid
);

    logic [CNT_W-1:0] best;

    always_comb begin
        found = 1'b0;
        tid   = '0;
        best  = '1;
        for (int i = 0; i < NTHR; i++) begin
            if (cand[i] && (!found || counts[i*CNT_W +: CNT_W] < best)) begin
                found = 1'b1;
                tid   = TID_W'(i);
                best  = counts[i*CNT_W +: CNT_W];
            end
        end
    end

endmodule

// File: rtl/fsel_rr_order.sv
`timescale 1ns/1ps
module fsel_rr_order #(
    parameter int NTHR = 4,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTHR-1:0]  cand,
    input  logic             advance,
    output logic             found,
    output logic [TID_W-1:0] tid
);

    typedef struct packed {
        logic [NTHR-1:0][TID_W-1:0] order;
    } rr_state_t;

    rr_state_t st_d, st_q;
    int unsigned hit_pos;

    always_comb begin
        st_d    = st_q;
        found   = 1'b0;
        tid     = '0;
        hit_pos = 0;
        for (int p = 0; p < NTHR; p++) begin
            if (!found && cand[st_q.order[p]]) begin
                found   = 1'b1;
                tid     = st_q.order[p];
                hit_pos = p;
            end
        end
        if (advance && found) begin
            for (int p = 0; p < NTHR - 1; p++) begin
                if (p >= hit_pos) begin
                    st_d.order[p] = st_q.order[p+1];
                end
            end
            st_d.order[NTHR-1] = tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTHR; i++) begin
                st_q.order[i] <= TID_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    logic [NTHR-1:0] present;
    always_comb begin
        present = '0;
        for (int i = 0; i < NTHR; i++) begin
            present[st_q.order[i]] = 1'b1;
        end
    end

    p_moves_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && found) |=> (st_q.order[NTHR-1] == $past(tid)));

    p_order_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && found) |=> $stable(st_q));

    p_permutation_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(present) == NTHR);

endmodule

// File: rtl/fetch_thread_sel.sv
`timescale 1ns/1ps
module fetch_thread_sel
    import fsel_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int CNT_W = 6,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTHR-1:0]       thr_active,
    input  logic [3*NTHR-1:0]     thr_state,
    input  logic [NTHR*CNT_W-1:0] iq_occ,
    input  logic [NTHR*CNT_W-1:0] lsq_occ,
    input  logic [2:0]            policy,
    input  logic                  drain_req,
    output logic                  sel_valid,
    output logic [TID_W-1:0]      sel_tid,
    output logic                  policy_err
);

    logic [NTHR-1:0] ready;
    always_comb begin
        for (int i = 0; i < NTHR; i++) begin
            ready[i] = thr_active[i] && state_ready(thr_state[3*i +: 3]);
        end
    end

    logic             one_hit;
    logic [TID_W-1:0] one_tid;
    always_comb begin
        one_hit = 1'b0;
        one_tid = '0;
        for (int i = NTHR - 1; i >= 0; i--) begin
            if (thr_active[i]) begin
                one_hit = 1'b1;
                one_tid = TID_W'(i);
            end
        end
    end

    logic             rr_found, iq_found, lsq_found;
    logic [TID_W-1:0] rr_tid, iq_tid, lsq_tid;
    logic             rr_advance;

    assign rr_advance = (policy == POL_ROTATE) && !drain_req;

    fsel_rr_order #(.NTHR(NTHR)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (ready),
        .advance (rr_advance),
        .found   (rr_found),
        .tid     (rr_tid)
    );

    fsel_min_pick #(.NTHR(NTHR), .CNT_W(CNT_W)) u_iq_pick (
        .cand   (ready),
        .counts (iq_occ),
        .found  (iq_found),
        .tid    (iq_tid)
    );

    fsel_min_pick #(.NTHR(NTHR), .CNT_W(CNT_W)) u_lsq_pick (
        .cand   (ready),
        .counts (lsq_occ),
        .found  (lsq_found),
        .tid    (lsq_tid)
    );

    logic             pick_v;
    logic [TID_W-1:0] pick_t;
    always_comb begin
        pick_v = 1'b0;
        pick_t = '0;
        case (policy)
            POL_SINGLE: begin
                pick_v = one_hit && ready[one_tid];
                pick_t = one_tid;
            end
            POL_ROTATE: begin
                pick_v = rr_found;
                pick_t = rr_tid;
            end
            POL_IQ: begin
                pick_v = iq_found;
                pick_t = iq_tid;
            end
            POL_LSQ: begin
                pick_v = lsq_found;
                pick_t = lsq_tid;
            end
            default: begin
                pick_v = 1'b0;
                pick_t = '0;
            end
        endcase
        policy_err = !policy_known(policy);
        sel_valid  = pick_v && !drain_req;
        sel_tid    = sel_valid ? pick_t : '0;
    end

    p_grant_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (thr_active[sel_tid] && state_ready(thr_state[3*sel_tid +: 3])));

    p_drain_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> !sel_valid);

    p_reserved_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        policy_err |-> !sel_valid);

    p_idle_tid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_tid == '0));

endmodule

// File: tb/fetch_thread_sel_bench.sv
`timescale 1ns/1ps
module fetch_thread_sel_bench;

    localparam int N  = 4;
    localparam int CW = 6;
    localparam int TW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    thr_active = '0;
    logic [3*N-1:0]  thr_state = '0;
    logic [N*CW-1:0] iq_occ = '0;
    logic [N*CW-1:0] lsq_occ = '0;
    logic [2:0]      policy = 3'd0;
    logic            drain_req = 1'b0;
    logic            sel_valid;
    logic [TW-1:0]   sel_tid;
    logic            policy_err;

    always #2.5 clk = ~clk;

    fetch_thread_sel #(.NTHR(N), .CNT_W(CW)) u_fetch_thread_sel (
        .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .thr_state(thr_state),
        .iq_occ(iq_occ), .lsq_occ(lsq_occ), .policy(policy), .drain_req(drain_req),
        .sel_valid(sel_valid), .sel_tid(sel_tid), .policy_err(policy_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int order[$];

    function automatic bit m_ready(int t);
        int s;
        s = thr_state[3*t +: 3];
        return thr_active[t] && (s == 0 || s == 1 || s == 4);
    endfunction

    function automatic int m_min(input logic [N*CW-1:0] c);
        int best;
        best = -1;
        for (int i = 0; i < N; i++)
            if (m_ready(i) && (best < 0 || c[i*CW +: CW] < c[best*CW +: CW])) best = i;
        return best;
    endfunction

    task automatic model(output bit v, output int t, output bit e, output int rr_pos);
        int pick;
        pick = -1;
        rr_pos = -1;
        e = !(policy == 0 || policy == 1 || policy == 3 || policy == 4);
        case (policy)
            3'd0: begin
                for (int i = N - 1; i >= 0; i--) if (thr_active[i]) pick = i;
                if (pick >= 0 && !m_ready(pick)) pick = -1;
            end
            3'd1: begin
                foreach (order[k]) if (rr_pos < 0 && m_ready(order[k])) rr_pos = k;
                if (rr_pos >= 0) pick = order[rr_pos];
            end
            3'd3: pick = m_min(iq_occ);
            3'd4: pick = m_min(lsq_occ);
            default: pick = -1;
        endcase
        v = (pick >= 0) && !drain_req;
        t = v ? pick : 0;
    endtask

    task automatic cycle(input string tag);
        bit v, e;
        int t, pos;
        #1;
        model(v, t, e, pos);
        checks++;
        if (sel_valid !== v || int'(sel_tid) !== t || policy_err !== e) begin
            errors++;
            $display("FAIL %s policy=%0d: valid/tid/err actual %0b/%0d/%0b expected %0b/%0d/%0b",
                     tag, policy, sel_valid, sel_tid, policy_err, v, t, e);
        end
        @(posedge clk);
        if (policy == 3'd1 && !drain_req && pos >= 0) begin
            int g;
            g = order[pos];
            order.delete(pos);
            order.push_back(g);
        end
        @(negedge clk);
    endtask

    task automatic set_thr(int i, bit a, int st, int iq, int lq);
        thr_active[i] = a;
        thr_state[3*i +: 3] = st[2:0];
        iq_occ[i*CW +: CW] = iq[CW-1:0];
        lsq_occ[i*CW +: CW] = lq[CW-1:0];
    endtask

    initial begin
        #500000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) order.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5 R3 R4: all threads ready, rotation from reset order
        for (int i = 0; i < N; i++) set_thr(i, 1, 0, 5, 5);
        policy = 3'd1;
        repeat (6) cycle("R5 R3 R4 rotation from reset");

        // R3 R4: thread skipped when not ready, still rotates
        set_thr(1, 1, 3, 5, 5);
        repeat (5) cycle("R3 R4 rotation with stalled thread");

        // R1: each state on thread 0 alone
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < N; i++) set_thr(i, 0, 0, 0, 0);
            set_thr(0, 1, s, 1, 1);
            policy = 3'd3;
            cycle("R1 eligibility by state");
        end
        set_thr(0, 0, 0, 1, 1);
        set_thr(2, 0, 4, 0, 0);
        cycle("R1 inactive ready-state thread");

        // R2: lowest active not ready blocks higher ready
        policy = 3'd0;
        set_thr(0, 0, 0, 0, 0); set_thr(1, 1, 5, 0, 0);
        set_thr(2, 1, 0, 0, 0); set_thr(3, 1, 1, 0, 0);
        cycle("R2 lowest active stalled");
        set_thr(1, 1, 4, 0, 0);
        cycle("R2 lowest active ready");

        // R6 R7: minimum and ties
        for (int i = 0; i < N; i++) set_thr(i, 1, 0, 9, 9);
        policy = 3'd3; cycle("R6 iq tie");
        set_thr(2, 1, 1, 3, 40); set_thr(3, 1, 0, 3, 2);
        cycle("R6 iq minimum tie lower id");
        policy = 3'd4; cycle("R7 lsq minimum");
        set_thr(3, 1, 6, 3, 2);
        cycle("R7 lsq minimum not ready");

        // R8: drain under each policy, rotation order kept
        drain_req = 1'b1;
        for (int p = 0; p < 5; p++) begin
            policy = p[2:0];
            cycle("R8 drain");
        end
        policy = 3'd1;
        repeat (3) cycle("R8 drain rotation frozen");
        drain_req = 1'b0;
        for (int i = 0; i < N; i++) set_thr(i, 1, 0, 9, 9);
        repeat (4) cycle("R8 rotation after drain");

        // R9: reserved codes
        for (int p = 0; p < 8; p++) begin
            policy = p[2:0];
            cycle("R9 policy code");
        end

        // R10: nothing ready
        for (int i = 0; i < N; i++) set_thr(i, 1, 7, 0, 0);
        for (int p = 0; p < 5; p++) begin
            policy = p[2:0];
            cycle("R10 nothing ready");
        end

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < N; i++)
                set_thr(i, ($urandom % 5) != 0, $urandom % 8, $urandom % 8, $urandom % 8);
            policy = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd1;
            drain_req = ($urandom % 12) == 0;
            case (policy)
                3'd0: cycle("R2 random");
                3'd1: cycle("R3 R4 random");
                3'd3: cycle("R6 random");
                3'd4: cycle("R7 random");
                default: cycle("R9 random");
            endcase
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule